// File: doc/BRIEF.md
# Serial Result Output Shifter

This block is the slave-side output stage of a sampling converter. The conversion sequencer hands it a 12-bit result with a one-cycle load strobe, and the block keeps that value in a holding register. A host reads the value by toggling a serial clock. The block returns a 16-bit frame on a data line with a separate output enable, for a pad with three-state drive. The frame is four zero bits, then the result from bit 11 down to bit 0.

The serial clock and the active-low convert-start line are sampled by the block's system clock, which must be well above the serial clock rate. All frame logic acts on the edges that this sampling detects. A frame state machine has four states. ST_ARMED waits, undriven, for the first rising serial clock edge. ST_SHIFT drives the frame and moves one bit on each falling edge. ST_DONE has released the line after the sixteenth falling edge. ST_WRAP is entered when extra clocks arrive after release; it replays the frame from bit 0 without end and keeps the line driven. The transitions are:
- ARMED to SHIFT on a rise.
- SHIFT to SHIFT on a falling edge before the last bit.
- SHIFT to DONE on the sixteenth falling edge.
- DONE to WRAP on a rise.
- WRAP to WRAP on every falling edge, with the bit index wrapping modulo 16.
- Any state to ARMED when convert-start falls while the serial clock is low (resync).

Top module: `serout_shifter`

## Requirements
- R1: Frame bit k (k = 0 is sent first) is 0 for k < 4 and result bit 15-k for 4 <= k <= 15, so the result goes out most significant bit first.
- R2: From ST_ARMED, the first rising serial clock edge enables the output and drives frame bit 0. Each later falling edge advances to the next bit.
- R3: A rising serial clock edge during a frame never changes the driven bit, so a host may sample on either edge.
- R4: The sixteenth falling edge of a frame deasserts the output enable (state ST_DONE).
- R5: A rising edge in ST_DONE drives frame bit 0 again. From then on every falling edge advances the index modulo 16, and the enable stays high through any pause until a resync.
- R6: A falling edge of convert-start while the serial clock is low returns to ST_ARMED with bit index 0 and the enable low.
- R7: A falling edge of convert-start while the serial clock is high is ignored: the driven bit and the enable do not change.
- R8: While neither line toggles, the data and enable outputs hold their values, so a frame may be read in bursts with pauses between them.
- R9: The holding register changes only on the load strobe. A resync without a load replays the previous result.
- R10: After reset the state is ST_ARMED, the enable is low and the held result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_stb | input | 1 | End-of-conversion strobe from the sequencer |
| load_data | input | 12 | Conversion result captured on load_stb |
| sclk | input | 1 | Serial clock from the host, already synchronized |
| conv_n | input | 1 | Active-low convert-start, already synchronized |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Output enable for the three-state pad |

## Verification
The bench reads complete frames for many result patterns: all-zero, all-one, single walking bits and checkerboards. It checks every bit on both serial clock edges, so a reversed bit order, a missing zero prefix or an advance on the wrong edge each show up as a wrong bit. It sends clocks past the sixteenth edge to catch a design that stays released, or that releases again instead of wrapping. It also pauses in the middle of a frame to catch outputs that drift. It raises convert-start edges with the serial clock both low and high: a design that ignored the level would restart in the middle of a frame, and one that ignored the edge would stay driven. A resync without a load then checks that the old result is replayed rather than cleared.

// File: rtl/serout_pkg.sv
package serout_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2,
        ST_WRAP  = 2'd3
    } frame_state_t;
endpackage

// File: rtl/serout_edge_det.sv
module serout_edge_det #(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LEVEL;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/serout_hold_reg.sv
module serout_hold_reg #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [RES_W-1:0] data_i,
    output logic [RES_W-1:0] data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_o <= '0;
        else if (load_i) data_o <= data_i;
    end
endmodule

// File: rtl/serout_bit_pick.sv
module serout_bit_pick #(
    parameter int RES_W = 12,
    parameter int PAD_W = 4
) (
    input  logic [RES_W-1:0]                   result_i,
    input  logic [$clog2(RES_W+PAD_W)-1:0]     idx_i,
    output logic                               bit_o
);
    localparam int FRAME_W = RES_W + PAD_W;

    logic [FRAME_W-1:0] frame_w;
    logic [FRAME_W-1:0] order_w;

    assign frame_w = {{PAD_W{1'b0}}, result_i};

    // order_w[k] is the bit sent in slot k (slot 0 first)
    for (genvar g = 0; g < FRAME_W; g++) begin : g_order
        assign order_w[g] = frame_w[FRAME_W-1-g];
    end

    assign bit_o = order_w[idx_i];
endmodule

// File: rtl/serout_shifter.sv
module serout_shifter
    import serout_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int PAD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [RES_W-1:0] load_data,
    input  logic             sclk,
    input  logic             conv_n,
    output logic             sdata_o,
    output logic             sdata_oe
);
    localparam int FRAME_W = RES_W + PAD_W;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    frame_state_t     state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             sclk_rise, sclk_fall;
    logic             conv_rise_unused, conv_fall;
    logic             resync;
    logic [RES_W-1:0] held_w;
    logic             bit_w;

    serout_edge_det #(.IDLE_LEVEL(1'b0)) sclk_det_i (
        .clk(clk), .rst_n(rst_n), .level_i(sclk),
        .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    serout_edge_det #(.IDLE_LEVEL(1'b1)) conv_det_i (
        .clk(clk), .rst_n(rst_n), .level_i(conv_n),
        .rise_o(conv_rise_unused), .fall_o(conv_fall)
    );

    serout_hold_reg #(.RES_W(RES_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_stb),
        .data_i(load_data), .data_o(held_w)
    );

    serout_bit_pick #(.RES_W(RES_W), .PAD_W(PAD_W)) pick_i (
        .result_i(held_w), .idx_i(idx_q), .bit_o(bit_w)
    );

    // resync only counts while the serial clock is low
    assign resync = conv_fall & ~sclk;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (resync) begin
            state_d = ST_ARMED;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    if (sclk_rise) begin
                        state_d = ST_SHIFT;
                        idx_d   = '0;
                    end
                end
                ST_SHIFT: begin
                    if (sclk_fall) begin
                        if (idx_q == LAST_IDX) begin
                            state_d = ST_DONE;
                            idx_d   = '0;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    if (sclk_rise) begin
                        state_d = ST_WRAP;
                        idx_d   = '0;
                    end
                end
                ST_WRAP: begin
                    if (sclk_fall) begin
                        idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        sdata_oe = 1'b0;
        sdata_o  = 1'b0;
        unique case (state_q)
            ST_ARMED, ST_DONE: begin
                sdata_oe = 1'b0;
                sdata_o  = 1'b0;
            end
            ST_SHIFT, ST_WRAP: begin
                sdata_oe = 1'b1;
                sdata_o  = bit_w;
            end
        endcase
    end
endmodule

// File: rtl/serout_shifter_chk.sv
module serout_shifter_chk
    import serout_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int PAD_W = 4
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               load_stb,
    input logic                               sclk,
    input logic                               sclk_rise,
    input logic                               sclk_fall,
    input logic                               conv_fall,
    input frame_state_t                       state_q,
    input logic [$clog2(RES_W+PAD_W)-1:0]     idx_q,
    input logic                               sdata_o,
    input logic                               sdata_oe
);
    localparam int FRAME_W = RES_W + PAD_W;

    a_r1_zero_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && int'(idx_q) < PAD_W) |-> !sdata_o);

    a_r3_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sclk_rise && !load_stb) |=> $stable(sdata_o));

    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sclk_fall && int'(idx_q) == FRAME_W - 1) |=> !sdata_oe);

    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && sclk_rise) |=> (sdata_oe && !sdata_o));

    a_r5_stay_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRAP && !(conv_fall && !sclk)) |=> sdata_oe);

    a_r6_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_fall && !sclk) |=> (!sdata_oe && idx_q == '0));

    a_r7_ignore_high: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_fall && sclk && !sclk_rise) |=> ($stable(sdata_o) && $stable(sdata_oe)));

    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !sclk_fall && !conv_fall && !load_stb)
        |=> ($stable(sdata_o) && $stable(sdata_oe)));
endmodule

bind serout_shifter serout_shifter_chk #(.RES_W(RES_W), .PAD_W(PAD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .sclk(sclk),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .conv_fall(conv_fall),
    .state_q(state_q), .idx_q(idx_q), .sdata_o(sdata_o), .sdata_oe(sdata_oe)
);

// File: tb/serout_shifter_tb_top.sv
module serout_shifter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_stb = 1'b0;
    logic [11:0] load_data = '0;
    logic        sclk = 1'b0;
    logic        conv_n = 1'b1;
    logic        sdata_o, sdata_oe;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    serout_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_data(load_data),
        .sclk(sclk), .conv_n(conv_n), .sdata_o(sdata_o), .sdata_oe(sdata_oe)
    );

    function automatic logic exp_bit(input logic [11:0] v, input int k);
        return (k < 4) ? 1'b0 : v[15-k];
    endfunction

    task automatic chk(input string req, input logic act_oe, input logic act_d,
                       input logic exp_oe, input logic exp_d);
        checks++;
        if (act_oe !== exp_oe || (exp_oe && act_d !== exp_d)) begin
            errors++;
            $display("FAIL %s: oe/data %b/%b expected %b/%b", req, act_oe, act_d, exp_oe, exp_d);
        end
    endtask

    // change a line at a falling clk edge, sample at the next falling edge
    task automatic set_sclk(input logic v);
        sclk = v;
        @(negedge clk);
    endtask

    task automatic set_conv(input logic v);
        conv_n = v;
        @(negedge clk);
    endtask

    task automatic load(input logic [11:0] v);
        load_data = v;
        load_stb  = 1'b1;
        @(negedge clk);
        load_stb  = 1'b0;
        @(negedge clk);
    endtask

    task automatic resync_low();
        set_conv(1'b0);
        chk("R6", sdata_oe, sdata_o, 1'b0, 1'b0);
        set_conv(1'b1);
    endtask

    task automatic read_frame(input logic [11:0] v, input int pause);
        chk("R2", sdata_oe, sdata_o, 1'b0, 1'b0);
        set_sclk(1'b1);
        chk("R2", sdata_oe, sdata_o, 1'b1, exp_bit(v, 0));
        for (int k = 1; k < 16; k++) begin
            set_sclk(1'b0);
            chk("R1", sdata_oe, sdata_o, 1'b1, exp_bit(v, k));
            if (pause > 0 && (k % 8) == 7) begin
                repeat (pause) @(negedge clk);
                chk("R8", sdata_oe, sdata_o, 1'b1, exp_bit(v, k));
            end
            set_sclk(1'b1);
            chk("R3", sdata_oe, sdata_o, 1'b1, exp_bit(v, k));
        end
        set_sclk(1'b0);
        chk("R4", sdata_oe, sdata_o, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: oe/data %b/%b expected run end", sdata_oe, sdata_o);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: armed, undriven, held value zero
        chk("R10", sdata_oe, sdata_o, 1'b0, 1'b0);
        read_frame(12'h000, 0);

        // sweep: walking ones, walking zeros and fixed patterns
        for (int p = 0; p < 28; p++) begin
            if (p < 12)      v = 12'(1) << p;
            else if (p < 24) v = ~(12'(1) << (p - 12));
            else if (p == 24) v = 12'hFFF;
            else if (p == 25) v = 12'hA5A;
            else if (p == 26) v = 12'h5A5;
            else              v = 12'h800;
            resync_low();
            load(v);
            read_frame(v, (p % 3 == 0) ? 20 : 0);
        end

        // R9: resync without load replays the previous result
        resync_low();
        read_frame(12'h800, 0);

        // R5: extra clocks replay the frame and stay driven
        load(12'hC3D);
        resync_low();
        read_frame(12'hC3D, 0);
        set_sclk(1'b1);
        chk("R5", sdata_oe, sdata_o, 1'b1, exp_bit(12'hC3D, 0));
        for (int f = 1; f <= 20; f++) begin
            set_sclk(1'b0);
            chk("R5", sdata_oe, sdata_o, 1'b1, exp_bit(12'hC3D, f % 16));
            set_sclk(1'b1);
        end
        set_sclk(1'b0);
        repeat (30) @(negedge clk);
        chk("R5", sdata_oe, sdata_o, 1'b1, exp_bit(12'hC3D, 21 % 16));

        // R6: resync while low releases the line
        resync_low();

        // R7: convert-start falls with sclk high mid-frame, ignored
        load(12'h9B6);
        resync_low();
        set_sclk(1'b1);
        for (int k = 1; k < 6; k++) begin
            set_sclk(1'b0);
            set_sclk(1'b1);
        end
        set_conv(1'b0);
        chk("R7", sdata_oe, sdata_o, 1'b1, exp_bit(12'h9B6, 5));
        set_conv(1'b1);
        for (int k = 6; k < 16; k++) begin
            set_sclk(1'b0);
            chk("R7", sdata_oe, sdata_o, 1'b1, exp_bit(12'h9B6, k));
            set_sclk(1'b1);
        end
        set_sclk(1'b0);
        chk("R4", sdata_oe, sdata_o, 1'b0, 1'b0);

        // R9: a load mid-idle does not disturb the undriven line
        load(12'h123);
        chk("R9", sdata_oe, sdata_o, 1'b0, 1'b0);
        resync_low();
        read_frame(12'h123, 5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule